// File: doc/BRIEF.md
# Process-Tagged Translation Buffer with Superpage Entries

This block is a small, fully associative cache of address translations. Every entry binds a process identifier and a virtual page number to a physical frame number. Each entry also carries a write-permission bit, a dirty bit and a flag that makes it cover a large, aligned group of pages. A requester presents the current process identifier, a virtual address and whether the access is a store. One cycle later the block reports one of three outcomes: a hit with the physical address, a miss, or a protection fault.

Translations are installed through a fill port by whatever agent resolves misses. A selective purge port removes the translations of one process for one page, which serves remote invalidation requests. A flush input empties the whole buffer in a single cycle, for example on a global remap.

Top module: `ptlb`

## Requirements
- R1: A lookup hits only on a valid entry whose process ID equals `lk_pid` and whose 20-bit page number equals `lk_va[31:12]`. On a hit, `res_pa` is the entry's frame number concatenated with `lk_va[11:0]`.
- R2: A lookup that matches no entry reports `res_miss`=1, with `res_hit`=0, `res_fault`=0, `res_pa`=0 and `res_dirty`=0.
- R3: A superpage entry (`fill_super`=1) compares only page bits [19:10]. Its `res_pa` is frame bits [19:10], followed by `lk_va[21:0]`. When a 4 KB entry and a superpage entry both match, the 4 KB entry is used. Among entries of the same kind, the lowest index is used.
- R4: A store (`lk_wr`=1) that matches an entry without write permission reports `res_fault`=1 and `res_hit`=0. It does not change the entry's dirty bit.
- R5: A store that hits a writable entry sets that entry's dirty bit. On a hit, `res_dirty` shows the entry's dirty bit as it stood before the access. On any other result `res_dirty` is 0.
- R6: A purge invalidates every entry that has process ID `purge_pid` and whose page matches `purge_vpn`. A superpage entry matches on bits [19:10] only. All other entries are unaffected.
- R7: `purge_all` invalidates every entry in one cycle. It overrides a fill made in the same cycle.
- R8: A fill writes the lowest-numbered invalid entry. When all 8 entries are valid, it writes the entry named by a round-robin pointer. The pointer starts at 0 and advances by one, modulo 8, after each such replacement.
- R9: Each result appears exactly one cycle after its request, with `res_valid`=1. Exactly one of `res_hit`, `res_miss` and `res_fault` is set on that result.
- R10: After reset all entries are invalid and every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_pid | input | 4 | Current process ID |
| lk_va | input | 32 | Virtual address |
| lk_wr | input | 1 | 1 for a store, 0 for a load |
| res_valid | output | 1 | Result present (one cycle after the request) |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No translation present |
| res_fault | output | 1 | Store to a read-only page |
| res_pa | output | 32 | Physical address on a hit |
| res_dirty | output | 1 | Dirty bit of the hit entry before this access |
| fill_en | input | 1 | Install a translation |
| fill_pid | input | 4 | Process ID of the new entry |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_pfn | input | 20 | Physical frame number of the new entry |
| fill_writable | input | 1 | 1 grants write permission |
| fill_dirty | input | 1 | Initial dirty bit |
| fill_super | input | 1 | Entry maps a superpage |
| purge_en | input | 1 | Selective invalidate request |
| purge_pid | input | 4 | Process ID to purge |
| purge_vpn | input | 20 | Page to purge |
| purge_all | input | 1 | Invalidate every entry |

## Verification
The assertions on dirty-bit setting assume that a fill does not target the same entry as a store hit in the same cycle. The stimulus keeps fills, purges and lookups in separate cycles, except for one cycle that deliberately combines flush and fill. The bench also never installs two entries that map the same page for the same process with the same size. This keeps the selection of the matching entry unambiguous apart from the deliberate overlap between a superpage entry and a 4 KB entry. Repeated sweeps over process IDs, pages and access types run after fills, replacements, purges and a flush.

// File: rtl/ptlb.sv
module ptlb #(
  parameter int ENTRIES   = 8,
  parameter int PID_W     = 4,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PFN_W     = 20,
  parameter int SP_BITS   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lk_req,
  input  logic [PID_W-1:0]           lk_pid,
  input  logic [VA_W-1:0]            lk_va,
  input  logic                       lk_wr,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic                       res_miss,
  output logic                       res_fault,
  output logic [PFN_W+PAGE_BITS-1:0] res_pa,
  output logic                       res_dirty,
  input  logic                       fill_en,
  input  logic [PID_W-1:0]           fill_pid,
  input  logic [VA_W-PAGE_BITS-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic                       fill_writable,
  input  logic                       fill_dirty,
  input  logic                       fill_super,
  input  logic                       purge_en,
  input  logic [PID_W-1:0]           purge_pid,
  input  logic [VA_W-PAGE_BITS-1:0]  purge_vpn,
  input  logic                       purge_all
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PA_W  = PFN_W + PAGE_BITS;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, wrt, drt, sup;
  logic [PID_W-1:0]   pid_q [ENTRIES];
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr;

  logic [VPN_W-1:0]   lk_vpn;
  logic [ENTRIES-1:0] sm, bm, pm;
  logic [IDX_W-1:0]   sel, vic;
  logic               found, use_rr;

  assign lk_vpn = lk_va[VA_W-1:PAGE_BITS];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic up_lk, up_pg;
    assign up_lk = vpn_q[g][VPN_W-1:SP_BITS] == lk_vpn[VPN_W-1:SP_BITS];
    assign up_pg = vpn_q[g][VPN_W-1:SP_BITS] == purge_vpn[VPN_W-1:SP_BITS];
    assign sm[g] = vld[g] && pid_q[g] == lk_pid && !sup[g] && vpn_q[g] == lk_vpn;
    assign bm[g] = vld[g] && pid_q[g] == lk_pid && sup[g] && up_lk;
    assign pm[g] = vld[g] && pid_q[g] == purge_pid &&
                   (sup[g] ? up_pg : vpn_q[g] == purge_vpn);
  end

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (bm[i]) begin sel = IDX_W'(i); found = 1'b1; end
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (sm[i]) begin sel = IDX_W'(i); found = 1'b1; end
  end

  always_comb begin
    vic    = rr;
    use_rr = 1'b1;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld[i]) begin vic = IDX_W'(i); use_rr = 1'b0; end
  end

  logic [PFN_W-1:0] pfn_s;
  logic [PA_W-1:0]  pa_c;
  logic             deny, grant;
  assign pfn_s = pfn_q[sel];
  assign pa_c  = sup[sel] ? {pfn_s[PFN_W-1:SP_BITS], lk_vpn[SP_BITS-1:0], lk_va[PAGE_BITS-1:0]}
                          : {pfn_s, lk_va[PAGE_BITS-1:0]};
  assign deny  = lk_req && found && lk_wr && !wrt[sel];
  assign grant = lk_req && found && !deny;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld       <= '0;
      rr        <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_miss  <= 1'b0;
      res_fault <= 1'b0;
      res_pa    <= '0;
      res_dirty <= 1'b0;
    end else begin
      res_valid <= lk_req;
      res_hit   <= grant;
      res_miss  <= lk_req && !found;
      res_fault <= deny;
      res_pa    <= grant ? pa_c : '0;
      res_dirty <= grant ? drt[sel] : 1'b0;
      if (purge_en) vld <= vld & ~pm;
      if (fill_en) begin
        vld[vic] <= 1'b1;
        if (use_rr) rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
      if (purge_all) vld <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (grant && lk_wr) drt[sel] <= 1'b1;
    if (fill_en) begin
      pid_q[vic] <= fill_pid;
      vpn_q[vic] <= fill_vpn;
      pfn_q[vic] <= fill_pfn;
      wrt[vic]   <= fill_writable;
      drt[vic]   <= fill_dirty;
      sup[vic]   <= fill_super;
    end
  end

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $countones({res_hit, res_miss, res_fault}) == 1);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> res_valid);
  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    purge_all |=> vld == '0);
  // R4
  fault_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_fault |-> $past(lk_wr));
  // R5
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && lk_wr && !fill_en) |=> drt[$past(sel)]);
  // R2
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_miss |-> (res_pa == '0 && !res_dirty));
endmodule

// File: tb/ptlb_tb_top.sv
module ptlb_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_req = 0, lk_wr = 0;
  logic [3:0]  lk_pid = 0;
  logic [31:0] lk_va = 0;
  logic        res_valid, res_hit, res_miss, res_fault, res_dirty;
  logic [31:0] res_pa;
  logic        fill_en = 0, fill_writable = 0, fill_dirty = 0, fill_super = 0;
  logic [3:0]  fill_pid = 0, purge_pid = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0, purge_vpn = 0;
  logic        purge_en = 0, purge_all = 0;

  always #10 clk = ~clk;

  ptlb dut_i (.*);

  int vecs = 0, errs = 0;
  bit          m_vld[8], m_wr[8], m_dt[8], m_sp[8];
  logic [3:0]  m_pid[8];
  logic [19:0] m_vpn[8], m_pfn[8];
  int          m_rr = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int m_find(logic [3:0] p, logic [19:0] v);
    int r = -1;
    for (int i = 7; i >= 0; i--)
      if (m_vld[i] && m_pid[i] == p && m_sp[i] && m_vpn[i][19:10] == v[19:10]) r = i;
    for (int i = 7; i >= 0; i--)
      if (m_vld[i] && m_pid[i] == p && !m_sp[i] && m_vpn[i] == v) r = i;
    return r;
  endfunction

  task automatic lookup(logic [3:0] p, logic [31:0] va, bit wr, string ph);
    int idx;
    bit eh, em, ef, ed;
    logic [31:0] epa;
    string tag;
    @(negedge clk);
    lk_req = 1; lk_pid = p; lk_va = va; lk_wr = wr;
    idx = m_find(p, va[31:12]);
    em = (idx < 0); ef = 0; eh = 0; ed = 0; epa = 0;
    if (!em) begin
      ef = wr && !m_wr[idx];
      eh = !ef;
      if (eh) begin
        ed  = m_dt[idx];
        epa = m_sp[idx] ? {m_pfn[idx][19:10], va[21:0]} : {m_pfn[idx], va[11:0]};
        if (wr) m_dt[idx] = 1;
      end
    end
    tag = em ? "R2" : ef ? "R4" : m_sp[idx] ? "R3" : wr ? "R5" : "R1";
    @(negedge clk);
    lk_req = 0;
    check({res_valid, res_hit, res_miss, res_fault, res_dirty, res_pa} ==
          {1'b1, eh, em, ef, ed, epa}, {tag, "/R9 ", ph},
          {27'd0, res_valid, res_hit, res_miss, res_fault, res_dirty, res_pa},
          {27'd0, 1'b1, eh, em, ef, ed, epa});
  endtask

  // R8 model of placement
  task automatic fill(logic [3:0] p, logic [19:0] v, logic [19:0] f, bit w, bit s);
    int vi = -1;
    @(negedge clk);
    fill_en = 1; fill_pid = p; fill_vpn = v; fill_pfn = f;
    fill_writable = w; fill_dirty = 0; fill_super = s;
    for (int i = 7; i >= 0; i--) if (!m_vld[i]) vi = i;
    if (vi < 0) begin vi = m_rr; m_rr = (m_rr + 1) % 8; end
    m_vld[vi] = 1; m_pid[vi] = p; m_vpn[vi] = v; m_pfn[vi] = f;
    m_wr[vi] = w; m_dt[vi] = 0; m_sp[vi] = s;
    @(negedge clk);
    fill_en = 0;
  endtask

  // R6 model of selective purge
  task automatic purge(logic [3:0] p, logic [19:0] v);
    @(negedge clk);
    purge_en = 1; purge_pid = p; purge_vpn = v;
    for (int i = 0; i < 8; i++)
      if (m_vld[i] && m_pid[i] == p &&
          (m_sp[i] ? m_vpn[i][19:10] == v[19:10] : m_vpn[i] == v)) m_vld[i] = 0;
    @(negedge clk);
    purge_en = 0;
  endtask

  function automatic logic [19:0] pg(int k);
    case (k)
      8: pg = 20'h00400; 9: pg = 20'h00405; 10: pg = 20'h007FF;
      11: pg = 20'h00800; 12: pg = 20'h00000; 13: pg = 20'h00108;
      default: pg = 20'h00100 + 20'(k);
    endcase
  endfunction

  task automatic sweep(string ph);
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 14; k++)
        for (int w = 0; w < 2; w++)
          lookup(4'(p), {pg(k), 12'((k * 37 + p * 5 + w * 911) % 4096)}, w[0], ph);
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check({res_valid, res_hit, res_miss, res_fault, res_dirty, res_pa} == '0, "R10 reset",
          {27'd0, res_valid, res_hit, res_miss, res_fault, res_dirty, res_pa}, 64'd0);
    sweep("R10 empty");
    for (int i = 0; i < 6; i++)
      fill(4'(i % 2), 20'h00100 + 20'(i), 20'h000A0 + 20'(i * 3), (i % 3) != 1, 1'b0);
    fill(4'd0, 20'h00400, 20'h01C00, 1'b1, 1'b1);   // R3 superpage
    fill(4'd0, 20'h00405, 20'h00333, 1'b0, 1'b0);   // R3 4 KB inside superpage wins
    sweep("R1 full");
    sweep("R5 second pass");
    fill(4'd2, 20'h00106, 20'h00777, 1'b1, 1'b0);   // R8 replaces entry 0
    fill(4'd2, 20'h00107, 20'h00778, 1'b0, 1'b0);   // R8 replaces entry 1
    sweep("R8 round robin");
    purge(4'd2, 20'h00101);                         // R6 wrong pid, no effect
    purge(4'd1, 20'h00103);                         // R6 entry 3
    sweep("R6 purge");
    fill(4'd1, 20'h00108, 20'h00999, 1'b1, 1'b0);   // R8 fills entry 3, not pointer
    sweep("R8 lowest invalid");
    purge(4'd0, 20'h007FF);                         // R6 superpage by inner page
    sweep("R6 superpage purge");
    @(negedge clk);                                 // R7 flush beats fill
    purge_all = 1; fill_en = 1; fill_pid = 0; fill_vpn = 20'h00100;
    fill_pfn = 20'h00111; fill_writable = 1; fill_super = 0;
    for (int i = 0; i < 8; i++) m_vld[i] = 0;
    @(negedge clk);
    purge_all = 0; fill_en = 0;
    sweep("R7 flush");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule